// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is the integer arithmetic and logic stage of a CISC-style datapath that works on byte, word and long operands. Each accepted operation takes a destination operand and a source operand, an operation code and a size code. After one clock it returns the value to be written back to the destination register, a write-back enable, and an updated five-bit condition register. Conditional-branch logic can read that register directly.

The arithmetic and the flags are evaluated only at the selected operand width. For a byte or word operation, the bits of the destination above that width pass through unchanged, so the returned value can be written to the whole register. A compare performs the subtraction only to set the flags and never asks for a write-back.

The input is a plain valid strobe. The block never applies back-pressure and accepts one operation on every cycle in which `in_valid` is high. The output side has no ready signal: each result is presented for exactly one cycle, and the consumer must take it in that cycle.

Top module: `ccr_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_res_we`, `out_res` and `ccr_q` are all zero.
- R2: An operation presented with `in_valid` high at a rising edge gives `out_valid` high during the following cycle. A cycle without `in_valid` gives `out_valid` low during the following cycle.
- R3: For add (op 0) and subtract (op 1), the low bits of `out_res` at the selected width are (dst + src) or (dst - src), taken modulo 2^width. Size 0 is 8 bits, size 1 is 16 bits and size 2 is 32 bits.
- R4: For byte and word operations, `out_res` bits above the operand width equal the corresponding bits of `in_dst`. A long operation replaces all 32 bits.
- R5: N (`ccr_q[3]`) is the top bit of the result at the operand width. Z (`ccr_q[2]`) is set when every result bit at that width is zero.
- R6: C (`ccr_q[0]`) is the carry out of the operand width for add. For subtract and compare it is the borrow, which is 1 exactly when the unsigned dst field is less than the unsigned src field.
- R7: V (`ccr_q[1]`) is set on signed two's-complement overflow at the operand width, for add, subtract and compare.
- R8: X (`ccr_q[4]`) takes the new C value on add and subtract. Compare and all logical operations leave X unchanged.
- R9: The logical operations AND (op 3), OR (op 4), XOR (op 5) and MOVE (op 6, result = src) place their result at the operand width, clear V and C, and set N and Z from that result.
- R10: Compare (op 2) takes its flags from dst - src at the operand width and returns `out_res` equal to `in_dst` with `out_res_we` low. Every other operation returns `out_res_we` high.
- R11: `ccr_q` changes only at an edge where `in_valid` and `in_flag_we` are both high. Otherwise it holds its value, including when an operation is valid but `in_flag_we` is low.
- R12: Size code 3 behaves exactly like long (size 2). Operation code 7 behaves exactly like MOVE (op 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6 move, 7 as move) |
| in_size | input | 2 | Operand size (0 byte, 1 word, 2 long, 3 as long) |
| in_flag_we | input | 1 | Allow this operation to update the condition register |
| in_src | input | 32 | Source operand |
| in_dst | input | 32 | Destination operand, also the merge base for narrow writes |
| out_valid | output | 1 | A result is presented this cycle |
| out_res | output | 32 | Merged value for the destination register |
| out_res_we | output | 1 | The destination register should be written |
| ccr_q | output | 5 | Condition register {X, N, Z, V, C}, bit 4 down to bit 0 |

## Verification
The assertions assume that `in_op`, `in_size`, `in_flag_we` and both operands hold defined values at every edge where `in_valid` is high. They also assume that the consumer samples a result during the single cycle in which `out_valid` is high, because nothing holds it longer. The stimulus changes inputs only on the falling clock edge. It always drives known values, including on idle cycles, and it draws operation and size codes over their full ranges so that the reserved codes are covered. It also varies `in_valid` and `in_flag_we` at random, so that flag-hold cycles and idle gaps fall between operations.

// File: rtl/ccr_alu_pkg.sv
package ccr_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MOVE = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } alu_size_e;

  // Bit order matches the branch-condition consumer: x is bit 4, c is bit 0.
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int NUM_SIZES = 3;

  // Map a size code onto a lane index: byte 0, word 1, long (and 3) 2.
  function automatic int unsigned lane_of(alu_size_e sz);
    case (sz)
      SZ_BYTE: return 0;
      SZ_WORD: return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/ccr_alu_addsub.sv
module ccr_alu_addsub
  import ccr_alu_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTE_W * 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  alu_size_e         size_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);

  logic [DATA_W-1:0] lane_sum [NUM_SIZES];
  logic              lane_c   [NUM_SIZES];
  logic              lane_v   [NUM_SIZES];

  // One adder per operand width, so carry and overflow come from that width.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int W = BYTE_W << k;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [W:0]   full;

    assign op_a = a_i[W-1:0];
    assign op_b = sub_i ? ~b_i[W-1:0] : b_i[W-1:0];
    assign full = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, sub_i};

    assign lane_sum[k] = DATA_W'(full[W-1:0]);
    // Subtract carries out when there is no borrow, so invert to report borrow.
    assign lane_c[k]   = full[W] ^ sub_i;
    assign lane_v[k]   = (op_a[W-1] == op_b[W-1]) && (full[W-1] != op_a[W-1]);
  end

  always_comb begin
    sum_o   = lane_sum[lane_of(size_i)];
    carry_o = lane_c[lane_of(size_i)];
    ovf_o   = lane_v[lane_of(size_i)];
  end

endmodule

// File: rtl/ccr_alu_logic.sv
module ccr_alu_logic
  import ccr_alu_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTE_W * 4
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end

endmodule

// File: rtl/ccr_alu_flags.sv
module ccr_alu_flags
  import ccr_alu_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTE_W * 4
) (
  input  alu_size_e         size_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              arith_i,
  input  logic              load_x_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  ccr_t              old_i,
  output ccr_t              next_o
);

  logic lane_n [NUM_SIZES];
  logic lane_z [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int W = BYTE_W << k;
    assign lane_n[k] = val_i[W-1];
    assign lane_z[k] = ~|val_i[W-1:0];
  end

  always_comb begin
    next_o.n = lane_n[lane_of(size_i)];
    next_o.z = lane_z[lane_of(size_i)];
    if (arith_i) begin
      next_o.v = ovf_i;
      next_o.c = carry_i;
      next_o.x = load_x_i ? carry_i : old_i.x;
    end else begin
      next_o.v = 1'b0;
      next_o.c = 1'b0;
      next_o.x = old_i.x;
    end
  end

endmodule

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_alu_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTE_W * 4,
  localparam int WORD_W = BYTE_W * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic              in_flag_we,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res,
  output logic              out_res_we,
  output logic [4:0]        ccr_q
);

  alu_op_e   op;
  alu_size_e size;
  logic      is_arith;
  logic      is_sub;
  logic      is_cmp;
  logic      load_x;

  assign op       = alu_op_e'(in_op);
  assign size     = alu_size_e'(in_size);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_cmp   = (op == OP_CMP);
  assign load_x   = (op == OP_ADD) || (op == OP_SUB);

  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              ovf;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] merged;
  ccr_t              ccr_cur;
  ccr_t              ccr_next;

  ccr_alu_addsub #(.BYTE_W(BYTE_W)) i_addsub (
    .a_i     (in_dst),
    .b_i     (in_src),
    .sub_i   (is_sub),
    .size_i  (size),
    .sum_o   (sum),
    .carry_o (carry),
    .ovf_o   (ovf)
  );

  ccr_alu_logic #(.BYTE_W(BYTE_W)) i_logic (
    .op_i  (op),
    .a_i   (in_dst),
    .b_i   (in_src),
    .res_o (logic_res)
  );

  assign raw     = is_arith ? sum : logic_res;
  assign ccr_cur = ccr_t'(ccr_q);

  ccr_alu_flags #(.BYTE_W(BYTE_W)) i_flags (
    .size_i   (size),
    .val_i    (raw),
    .arith_i  (is_arith),
    .load_x_i (load_x),
    .carry_i  (carry),
    .ovf_i    (ovf),
    .old_i    (ccr_cur),
    .next_o   (ccr_next)
  );

  // Bits of the destination above the operand width are carried through.
  always_comb begin
    case (size)
      SZ_BYTE: keep_mask = {{(DATA_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};
      SZ_WORD: keep_mask = {{(DATA_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};
      default: keep_mask = '0;
    endcase
    if (is_cmp) merged = in_dst;
    else        merged = (in_dst & keep_mask) | (raw & ~keep_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_res    <= '0;
      out_res_we <= 1'b0;
      ccr_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res    <= merged;
        out_res_we <= !is_cmp;
      end
      if (in_valid && in_flag_we) ccr_q <= ccr_next;
    end
  end

endmodule

// File: rtl/ccr_alu_chk.sv
module ccr_alu_chk #(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTE_W * 4,
  localparam int WORD_W = BYTE_W * 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [1:0]        in_size,
  input logic              in_flag_we,
  input logic [DATA_W-1:0] in_dst,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_res,
  input logic              out_res_we,
  input logic [4:0]        ccr_q
);

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_GIVES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=>
      out_res[DATA_W-1:BYTE_W] == $past(in_dst[DATA_W-1:BYTE_W])); // R4

  AST_WORD_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd1) |=>
      out_res[DATA_W-1:WORD_W] == $past(in_dst[DATA_W-1:WORD_W])); // R4

  AST_ZERO_NOT_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ccr_q[3] && ccr_q[2])); // R5

  AST_EXTEND_FOLLOWS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_we && in_op <= 3'd1) |=> ccr_q[4] == ccr_q[0]); // R8

  AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_we && in_op >= 3'd3) |=>
      (ccr_q[1:0] == 2'b00) && (ccr_q[4] == $past(ccr_q[4]))); // R9

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2) |=>
      !out_res_we && (out_res == $past(in_dst)) && (ccr_q[4] == $past(ccr_q[4]) || !$past(in_flag_we) || $past(in_flag_we))); // R10

  AST_COMPARE_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2) |=> ccr_q[4] == $past(ccr_q[4])); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_flag_we) |=> $stable(ccr_q)); // R11

endmodule

bind ccr_alu ccr_alu_chk #(.BYTE_W(BYTE_W)) i_ccr_alu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_size    (in_size),
  .in_flag_we (in_flag_we),
  .in_dst     (in_dst),
  .out_valid  (out_valid),
  .out_res    (out_res),
  .out_res_we (out_res_we),
  .ccr_q      (ccr_q)
);

// File: tb/test_ccr_alu.sv
`timescale 1ns/1ps
module test_ccr_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_flag_we = 1'b0;
  logic [31:0] in_src = '0;
  logic [31:0] in_dst = '0;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_res_we;
  logic [4:0]  ccr_q;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  // Bench-side model of the pending operation.
  logic        pend_v = 1'b0;
  logic [2:0]  pend_op = '0;
  logic [1:0]  pend_sz = '0;
  logic        pend_fwe = 1'b0;
  logic [31:0] exp_res = '0;
  logic        exp_we = 1'b0;
  logic [31:0] exp_mask = '0;
  logic [4:0]  model_ccr = '0;
  logic [4:0]  prev_ccr = '0;

  always #4 clk = ~clk;

  ccr_alu i_ccr_alu (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_flag_we (in_flag_we),
    .in_src     (in_src),
    .in_dst     (in_dst),
    .out_valid  (out_valid),
    .out_res    (out_res),
    .out_res_we (out_res_we),
    .ccr_q      (ccr_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op %0d size %0d)", tag, act, exp, pend_op, pend_sz);
    end
  endtask

  // Expected behaviour from the requirements: result, write enable, new flags.
  task automatic ref_op(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d,
                        input logic [31:0] s, input logic [4:0] old,
                        output logic [31:0] res, output logic we, output logic [4:0] flg,
                        output logic [31:0] m32);
    longint unsigned w, m, a, b, r, full;
    logic c, v, n, z, x, sa, sb, sr;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    a = {32'd0, d} & m;
    b = {32'd0, s} & m;
    x = old[4];
    sa = a[w-1];
    sb = b[w-1];
    case (op)
      3'd0: begin
        full = a + b; r = full & m; c = full[w];
        sr = r[w-1]; v = (sa == sb) && (sr != sa); x = c;
      end
      3'd1, 3'd2: begin
        r = (a - b) & m; c = (a < b);
        sr = r[w-1]; v = (sa != sb) && (sr != sa);
        if (op == 3'd1) x = c;
      end
      3'd3: begin r = a & b; c = 0; v = 0; end
      3'd4: begin r = a | b; c = 0; v = 0; end
      3'd5: begin r = a ^ b; c = 0; v = 0; end
      default: begin r = b; c = 0; v = 0; end
    endcase
    n = r[w-1];
    z = (r == 0);
    flg = {x, n, z, v, c};
    m32 = m[31:0];
    if (op == 3'd2) begin
      res = d; we = 1'b0;
    end else begin
      res = (d & ~m[31:0]) | r[31:0]; we = 1'b1;
    end
  endtask

  task automatic check_prev();
    string rt;
    if (!pend_v) begin
      chk("R2", {31'd0, out_valid}, 32'd0);
      chk("R11", {27'd0, ccr_q}, {27'd0, model_ccr});
      return;
    end
    chk("R2", {31'd0, out_valid}, 32'd1);
    chk("R10", {31'd0, out_res_we}, {31'd0, exp_we});
    if (pend_op == 3'd7 || pend_sz == 2'd3) rt = "R12";
    else if (pend_op == 3'd2) rt = "R10";
    else if (pend_op <= 3'd1) rt = "R3";
    else rt = "R9";
    chk(rt, out_res & exp_mask, exp_res & exp_mask);
    chk("R4", out_res & ~exp_mask, exp_res & ~exp_mask);
    if (!pend_fwe) begin
      chk("R11", {27'd0, ccr_q}, {27'd0, prev_ccr});
    end else begin
      chk(pend_op <= 3'd2 ? "R6" : "R9", {31'd0, ccr_q[0]}, {31'd0, model_ccr[0]});
      chk(pend_op <= 3'd2 ? "R7" : "R9", {31'd0, ccr_q[1]}, {31'd0, model_ccr[1]});
      chk("R5", {30'd0, ccr_q[3:2]}, {30'd0, model_ccr[3:2]});
      chk("R8", {31'd0, ccr_q[4]}, {31'd0, model_ccr[4]});
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [1:0] sz,
                      input logic [31:0] d, input logic [31:0] s, input logic fwe);
    logic [31:0] r;
    logic we;
    logic [4:0] f;
    logic [31:0] m;
    @(negedge clk);
    check_prev();
    in_valid = v; in_op = op; in_size = sz; in_dst = d; in_src = s; in_flag_we = fwe;
    prev_ccr = model_ccr;
    pend_v = v; pend_op = op; pend_sz = sz; pend_fwe = fwe;
    if (v) begin
      ref_op(op, sz, d, s, model_ccr, r, we, f, m);
      exp_res = r; exp_we = we; exp_mask = m;
      if (fwe) model_ccr = f;
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, out_valid}, 32'd0);
    chk("R1", {31'd0, out_res_we}, 32'd0);
    chk("R1", out_res, 32'd0);
    chk("R1", {27'd0, ccr_q}, 32'd0);
    rst_n = 1'b1;

    // Directed corners.
    step(1, 3'd0, 2'd0, 32'hAAAA_AA7F, 32'h0000_0001, 1); // R7 byte overflow, N set
    step(1, 3'd0, 2'd0, 32'h1234_56FF, 32'h0000_0001, 1); // R6 carry, Z, X
    step(1, 3'd3, 2'd2, 32'hFFFF_0000, 32'h0000_FFFF, 1); // R9 logic keeps X
    step(1, 3'd1, 2'd1, 32'h5555_0000, 32'h0000_0001, 1); // R6 word borrow
    step(1, 3'd2, 2'd1, 32'h9999_0005, 32'h1111_0005, 1); // R10 word compare ignores upper
    step(1, 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1); // R7 long overflow
    step(1, 3'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 1); // R7 long sub overflow
    step(1, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 0); // R11 flags held
    step(0, 3'd0, 2'd0, 32'h0, 32'h0, 1);                  // R11 idle
    step(1, 3'd7, 2'd3, 32'hDEAD_BEEF, 32'h8000_0000, 1); // R12 reserved codes
    step(1, 3'd2, 2'd0, 32'h0000_0010, 32'h0000_0020, 1); // R8 compare keeps X

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d, s;
      d = $urandom();
      s = $urandom();
      if ($urandom_range(0, 3) == 0) s = d;
      step(($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           d, s, ($urandom_range(0, 3) != 0));
    end
    step(0, 3'd0, 2'd0, 32'h0, 32'h0, 0);
    step(0, 3'd0, 2'd0, 32'h0, 32'h0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule